// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block runs one 8-bit general-purpose I/O port from a simple register bus. It holds three per-pin controls. The direction register decides whether each pin drives. The data register sets the driven level, or turns on a pull-up when the pin is an input. The pin-input register shows what the pad is doing now. Each of these is written with its own strobe. The controls are reached through one shared write-data bus and one shared read-data bus.

The pad is modelled as four bit vectors: output enable, output value, pull-up enable and pad input. The pad input passes through a two-stage synchronizer. The first stage is a latch that is transparent while the clock is low. The second stage is a flop that captures on the rising edge. A sleep input clamps the synchronizer input to zero. A shared pull-up-kill input turns off every pull-up.

Writing ones to the pin-input register flips the matching data bits. This lets software change an output level with a single write.

Top module: `pio_bank`

## Requirements
- R1: A cycle with `wr_dir` high loads `wdata` into the direction register on the next rising edge. `pad_oe[i]` equals direction bit i.
- R2: `pad_out[i]` equals data bit i when direction bit i is 1. It is 0 when direction bit i is 0.
- R3: `pad_pu[i]` is 1 exactly when direction bit i is 0, data bit i is 1 and `pull_off_all` is 0.
- R4: While `rst_n` is low, the direction and data registers are zero without waiting for a clock edge. As a result, `pad_oe`, `pad_out` and `pad_pu` are all zero.
- R5: A cycle with `wr_data` high loads `wdata` into the data register.
- R6: A cycle with `wr_pin` high, and without `wr_data`, flips each data bit whose `wdata` bit is 1. Data bits whose `wdata` bit is 0 keep their value.
- R7: When `wr_data` and `wr_pin` are high in the same cycle, `wr_data` wins and no bit is flipped.
- R8: A pad level applied while the clock is low is returned by a pin read after the next rising edge.
- R9: While `sleep_req` is high, the synchronizer input is forced to 0. A pin read after the next rising edge returns 0 whatever the pad does.
- R10: `rdata` is combinational. It returns the direction register on `rd_dir`, the data register on `rd_data`, and the synchronized pin state on `rd_pin`. The priority is `rd_dir` over `rd_data` over `rd_pin`. With no read strobe, `rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I/O clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_dir | input | 1 | Write strobe for the direction register |
| wr_data | input | 1 | Write strobe for the data register |
| wr_pin | input | 1 | Write strobe for the pin-input address (toggle) |
| wdata | input | 8 | Write data |
| rd_dir | input | 1 | Read strobe for the direction register |
| rd_data | input | 1 | Read strobe for the data register |
| rd_pin | input | 1 | Read strobe for the synchronized pin state |
| rdata | output | 8 | Read data |
| pull_off_all | input | 1 | Global pull-up disable |
| sleep_req | input | 1 | Clamps the input path to zero |
| pad_in | input | 8 | Pad input levels |
| pad_oe | output | 8 | Pad output enables |
| pad_out | output | 8 | Pad output values |
| pad_pu | output | 8 | Pad pull-up enables |

## Verification
The sleep and synchronizer properties assume that `sleep_req` changes only at a falling clock edge. Under that assumption, the value sampled at a rising edge is the value the latch saw during the whole preceding low phase. The read property assumes at most one read strobe is active at a time. The bench drives every input, pad levels included, just after a falling edge, and it never raises two read strobes together except in the one scenario that checks priority at the ports.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int unsigned PIO_W = 8;
  localparam int unsigned RST_STAGES = 2;

  typedef enum logic [1:0] {
    RSEL_NONE = 2'd0,
    RSEL_DIR  = 2'd1,
    RSEL_DATA = 2'd2,
    RSEL_PIN  = 2'd3
  } rsel_e;
endpackage

// File: rtl/pio_regs.sv
module pio_regs #(
  parameter int unsigned W = pio_pkg::PIO_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_dir,
  input  logic         wr_data,
  input  logic         wr_pin,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] data_q
);
  logic [W-1:0] dir_d, data_d;
  logic         dir_en, data_en;

  always_comb begin
    dir_en  = wr_dir;
    dir_d   = wdata;
    data_en = wr_data | wr_pin;
    if (wr_data) data_d = wdata;
    else         data_d = data_q ^ wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      data_q <= '0;
    end else begin
      if (dir_en)  dir_q  <= dir_d;
      if (data_en) data_q <= data_d;
    end
  end
endmodule

// File: rtl/pio_insync.sv
module pio_insync #(
  parameter int unsigned W = pio_pkg::PIO_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sleep_req,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pin_q
);
  logic [W-1:0] gated;
  logic [W-1:0] lat_q;

  always_comb gated = sleep_req ? '0 : pad_in;

  always_latch begin
    if (!clk) lat_q = gated;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= '0;
    else        pin_q <= lat_q;
  end
endmodule

// File: rtl/pio_padctl.sv
module pio_padctl #(
  parameter int unsigned W = pio_pkg::PIO_W
) (
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] data_q,
  input  logic         pull_off_all,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_pu
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      pad_oe[i]  = dir_q[i];
      pad_out[i] = dir_q[i] & data_q[i];
      pad_pu[i]  = ~dir_q[i] & data_q[i] & ~pull_off_all;
    end
  end
endmodule

// File: rtl/pio_bank.sv
module pio_bank #(
  parameter int unsigned W = pio_pkg::PIO_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_dir,
  input  logic         wr_data,
  input  logic         wr_pin,
  input  logic [W-1:0] wdata,
  input  logic         rd_dir,
  input  logic         rd_data,
  input  logic         rd_pin,
  output logic [W-1:0] rdata,
  input  logic         pull_off_all,
  input  logic         sleep_req,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_pu
);
  import pio_pkg::*;

  localparam int unsigned NS = RST_STAGES;

  logic [NS-1:0] rst_sh;
  logic          rst_sync_n;
  logic [W-1:0]  dir_q, data_q, pin_q;
  rsel_e         rsel;

  // reset: asserted asynchronously, released through NS flops
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh <= '0;
    else        rst_sh <= {rst_sh[NS-2:0], 1'b1};
  end
  assign rst_sync_n = rst_sh[NS-1];

  pio_regs #(.W(W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_dir (wr_dir),
    .wr_data(wr_data),
    .wr_pin (wr_pin),
    .wdata  (wdata),
    .dir_q  (dir_q),
    .data_q (data_q)
  );

  pio_insync #(.W(W)) u_sync (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .sleep_req(sleep_req),
    .pad_in   (pad_in),
    .pin_q    (pin_q)
  );

  pio_padctl #(.W(W)) u_pad (
    .dir_q       (dir_q),
    .data_q      (data_q),
    .pull_off_all(pull_off_all),
    .pad_oe      (pad_oe),
    .pad_out     (pad_out),
    .pad_pu      (pad_pu)
  );

  always_comb begin
    if      (rd_dir)  rsel = RSEL_DIR;
    else if (rd_data) rsel = RSEL_DATA;
    else if (rd_pin)  rsel = RSEL_PIN;
    else              rsel = RSEL_NONE;
  end

  always_comb begin
    unique case (rsel)
      RSEL_DIR:  rdata = dir_q;
      RSEL_DATA: rdata = data_q;
      RSEL_PIN:  rdata = pin_q;
      default:   rdata = '0;
    endcase
  end
endmodule

module pio_bank_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         rst_sync_n,
  input logic         wr_dir,
  input logic         wr_data,
  input logic         wr_pin,
  input logic [W-1:0] wdata,
  input logic         rd_pin,
  input logic         rd_dir,
  input logic         rd_data,
  input logic [W-1:0] rdata,
  input logic         pull_off_all,
  input logic         sleep_req,
  input logic [W-1:0] pad_oe,
  input logic [W-1:0] pad_pu,
  input logic [W-1:0] data_q,
  input logic [W-1:0] pin_q
);
  a_r1_oe_loads: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_dir |=> pad_oe == $past(wdata));

  a_r3_pu_needs_input: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pad_pu & pad_oe) == '0 && (pull_off_all -> pad_pu == '0));

  a_r4_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (pad_oe == '0 && pad_pu == '0));

  a_r6_toggle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_pin && !wr_data) |=> data_q == ($past(data_q) ^ $past(wdata)));

  a_r7_data_wins: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_data |=> data_q == $past(wdata));

  a_r9_sleep_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sleep_req |=> pin_q == '0);

  a_r10_pin_read: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_pin && !rd_dir && !rd_data) |-> rdata == pin_q);
endmodule

bind pio_bank pio_bank_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rst_sync_n  (rst_sync_n),
  .wr_dir      (wr_dir),
  .wr_data     (wr_data),
  .wr_pin      (wr_pin),
  .wdata       (wdata),
  .rd_pin      (rd_pin),
  .rd_dir      (rd_dir),
  .rd_data     (rd_data),
  .rdata       (rdata),
  .pull_off_all(pull_off_all),
  .sleep_req   (sleep_req),
  .pad_oe      (pad_oe),
  .pad_pu      (pad_pu),
  .data_q      (data_q),
  .pin_q       (pin_q)
);

// File: tb/test_pio_bank.sv
`timescale 1ns/100ps
module test_pio_bank;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_dir, wr_data, wr_pin;
  logic [7:0] wdata;
  logic       rd_dir, rd_data, rd_pin;
  logic [7:0] rdata;
  logic       pull_off_all, sleep_req;
  logic [7:0] pad_in, pad_oe, pad_out, pad_pu;

  int checks = 0;
  int errors = 0;
  logic [7:0] m_dir, m_data;

  always #2 clk = ~clk;

  pio_bank i_pio_bank (
    .clk(clk), .rst_n(rst_n), .wr_dir(wr_dir), .wr_data(wr_data), .wr_pin(wr_pin),
    .wdata(wdata), .rd_dir(rd_dir), .rd_data(rd_data), .rd_pin(rd_pin), .rdata(rdata),
    .pull_off_all(pull_off_all), .sleep_req(sleep_req), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input int kind, input logic [7:0] v);
    @(negedge clk);
    wdata = v;
    wr_dir  = (kind == 0);
    wr_data = (kind == 1);
    wr_pin  = (kind == 2);
    @(negedge clk);
    wr_dir = 1'b0; wr_data = 1'b0; wr_pin = 1'b0;
  endtask

  task automatic rd(input int kind, output logic [7:0] v);
    rd_dir  = (kind == 0);
    rd_data = (kind == 1);
    rd_pin  = (kind == 2);
    #0.5 v = rdata;
    rd_dir = 1'b0; rd_data = 1'b0; rd_pin = 1'b0;
  endtask

  task automatic check_pads(input string req);
    chk({req, " oe"}, pad_oe, m_dir);
    chk({req, " out"}, pad_out, m_dir & m_data);
    chk({req, " pu"}, pad_pu, ~m_dir & m_data & {8{~pull_off_all}});
  endtask

  task automatic t_reset_state;
    logic [7:0] v;
    @(negedge clk);
    check_pads("R4 reset");
    rd(0, v); chk("R10 dir after reset", v, 8'h00);
    rd(1, v); chk("R10 data after reset", v, 8'h00);
    rd(3, v); chk("R10 no strobe", v, 8'h00);
  endtask

  task automatic t_dir_and_drive;
    logic [7:0] v;
    wr(0, 8'hF0); m_dir = 8'hF0;
    wr(1, 8'h3C); m_data = 8'h3C;
    check_pads("R1 R2 R3 R5");
    rd(0, v); chk("R1 R10 dir readback", v, 8'hF0);
    rd(1, v); chk("R5 R10 data readback", v, 8'h3C);
    wr(0, 8'h0F); m_dir = 8'h0F;
    check_pads("R1 R2 R3 swap");
  endtask

  task automatic t_pull_kill;
    @(negedge clk); pull_off_all = 1'b1;
    #0.5 chk("R3 pull kill", pad_pu, 8'h00);
    @(negedge clk); pull_off_all = 1'b0;
    #0.5 check_pads("R3 pull restore");
  endtask

  task automatic t_toggle;
    logic [7:0] v;
    wr(2, 8'h81); m_data = m_data ^ 8'h81;
    rd(1, v); chk("R6 toggle", v, m_data);
    wr(2, 8'h00);
    rd(1, v); chk("R6 zero no effect", v, m_data);
    check_pads("R6 pads");
    @(negedge clk);
    wdata = 8'h55; wr_data = 1'b1; wr_pin = 1'b1;
    @(negedge clk);
    wr_data = 1'b0; wr_pin = 1'b0; m_data = 8'h55;
    rd(1, v); chk("R7 data wins", v, 8'h55);
  endtask

  task automatic t_pin_sync;
    logic [7:0] v;
    @(negedge clk); pad_in = 8'hA5;
    @(negedge clk); rd(2, v); chk("R8 pin after one edge", v, 8'hA5);
    pad_in = 8'h5A;
    @(negedge clk); rd(2, v); chk("R8 pin second value", v, 8'h5A);
  endtask

  task automatic t_sleep;
    logic [7:0] v;
    @(negedge clk); pad_in = 8'hFF; sleep_req = 1'b1;
    @(negedge clk); rd(2, v); chk("R9 sleep clamps", v, 8'h00);
    @(negedge clk); sleep_req = 1'b0;
    @(negedge clk); rd(2, v); chk("R9 wake", v, 8'hFF);
  endtask

  task automatic t_read_priority;
    logic [7:0] v;
    @(negedge clk);
    rd_dir = 1'b1; rd_data = 1'b1; rd_pin = 1'b1;
    #0.5 v = rdata; chk("R10 dir first", v, m_dir);
    rd_dir = 1'b0;
    #0.5 v = rdata; chk("R10 data second", v, m_data);
    rd_data = 1'b0; rd_pin = 1'b0;
  endtask

  task automatic t_async_reset;
    wr(0, 8'hFF); m_dir = 8'hFF;
    wr(1, 8'hAA); m_data = 8'hAA;
    @(negedge clk);
    #0.5 rst_n = 1'b0;
    #0.5 m_dir = 8'h00; m_data = 8'h00;
    check_pads("R4 async clear");
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #150000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    wr_dir = 0; wr_data = 0; wr_pin = 0; wdata = '0;
    rd_dir = 0; rd_data = 0; rd_pin = 0;
    pull_off_all = 0; sleep_req = 0; pad_in = '0;
    m_dir = '0; m_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset_state();
    t_dir_and_drive();
    t_pull_kill();
    t_toggle();
    t_pin_sync();
    t_sleep();
    t_read_priority();
    t_async_reset();
    t_reset_state();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule